// File: doc/BRIEF.md
# SPI word-packing byte FIFO

This block holds the transmit and receive data of an SPI master. Each direction keeps a byte-wide FIFO of 32 entries. Software reaches each side through one 32-bit data word: a write strobe packs up to four bytes into the transmit FIFO, and a read strobe unpacks up to four received bytes into one word. A per-direction swap input picks whether the first byte travels in the low or the high lane of the word.

The serial shifter sees a plain byte stream: it takes transmit bytes one at a time with a take strobe and pushes each received byte with a push strobe. A programmed packet byte count trims the final transmit word of a packet, so a length that is not a multiple of four never sends the unused lanes. A soft reset input empties both FIFOs at once.

Top module: `spi_word_fifo`

## Requirements
- R1: Each direction stores up to 32 bytes; eight full-word writes fill the transmit FIFO without error.
- R2: With `tx_swap` low, a written word enters the transmit stream as bits 7:0 first, then 15:8, 23:16 and 31:24.
- R3: With `tx_swap` high, the order is reversed: bits 31:24 go first and bits 7:0 last.
- R4: A write pushes min(4, `pkt_bytes` minus the bytes already accepted in the packet) bytes, taking the first ones in send order; the other lanes are dropped and never appear on `tx_byte`.
- R5: With `rx_swap` low, a read returns the oldest received byte in bits 7:0 and the next ones in rising lanes, and removes up to four bytes.
- R6: With `rx_swap` high, the oldest received byte is returned in bits 31:24 and the next ones in falling lanes.
- R7: When fewer than four bytes are held, a read returns zero in the lanes of the missing bytes; reading an empty FIFO returns zero and leaves the stored bytes and their order untouched.
- R8: A write whose bytes do not fit in the free transmit space pushes nothing and sets `tx_ovf`, which stays set until a soft reset.
- R9: One cycle of `soft_rst` empties both FIFOs, clears `tx_ovf` and restarts the packet byte count; after reset both FIFOs are empty and `tx_ovf` is low.
- R10: A byte pushed by the shifter while the receive FIFO holds 32 bytes is dropped.
- R11: Once a packet's `pkt_bytes` have been accepted, the next write starts a new packet with its own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of both FIFOs, overflow flag and packet count |
| tx_swap | input | 1 | Transmit lane order: 0 low lane first, 1 high lane first |
| rx_swap | input | 1 | Receive lane order: 0 low lane first, 1 high lane first |
| pkt_bytes | input | 6 | Bytes in one transmit packet (0 disables pushes) |
| tx_wr | input | 1 | Write strobe of the transmit data word |
| tx_wdata | input | 32 | Transmit data word |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit FIFO holds at least one byte |
| tx_take | input | 1 | Shifter takes `tx_byte` |
| rx_byte | input | 8 | Byte from the shifter |
| rx_push | input | 1 | Shifter pushes `rx_byte` |
| rx_avail | output | 1 | Receive FIFO holds at least one byte |
| rx_rd | input | 1 | Read strobe of the receive data word |
| rx_rdata | output | 32 | Receive data word, valid while `rx_rd` is sampled |

## Verification
A corrupted pointer or count shows up on the very next byte taken or word read: a wrong read pointer gives a byte out of order on `tx_byte` or in the wrong lane of `rx_rdata`, and a wrong count shows as a premature or late drop of `tx_avail` or `rx_avail`, or as stale nonzero data in a lane that should read zero. A wrong packet counter shows within one packet, as the wrong number of bytes drained after a trimmed final word. The scoreboard therefore compares every byte and every word against a model queue, and checks the empty flags after each drain.

// File: rtl/spi_wf_pkg.sv
package spi_wf_pkg;
   localparam int unsigned DEF_DEPTH  = 32;
   localparam int unsigned DEF_LANES  = 4;
   localparam int unsigned DEF_BYTE_W = 8;
endpackage

// File: rtl/spi_wf_lane_order.sv
module spi_wf_lane_order #(
   parameter int unsigned LANES = 4,
   parameter int unsigned BW    = 8
) (
   input  logic                  swap,
   input  logic [LANES*BW-1:0]   din,
   output logic [LANES*BW-1:0]   dout
);
   if (LANES < 1) begin : g_bad_lanes
      $error("spi_wf_lane_order: LANES must be at least 1");
   end

   // Lane k of the output is lane k (straight) or lane LANES-1-k (swapped).
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign dout[k*BW +: BW] = swap ? din[(LANES-1-k)*BW +: BW] : din[k*BW +: BW];
   end
endmodule

// File: rtl/spi_wf_byte_fifo.sv
module spi_wf_byte_fifo #(
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned WR_LANES = 4,
   parameter int unsigned RD_LANES = 1,
   parameter int unsigned BW       = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic [$clog2(WR_LANES+1)-1:0]     push_n,
   input  logic [WR_LANES*BW-1:0]            din,
   input  logic [$clog2(RD_LANES+1)-1:0]     pop_n,
   output logic [RD_LANES*BW-1:0]            dout,
   output logic [$clog2(DEPTH+1)-1:0]        count
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH+1);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("spi_wf_byte_fifo: DEPTH must be a power of two of at least 2");
   end
   if (DEPTH < WR_LANES || DEPTH < RD_LANES) begin : g_bad_lanes
      $error("spi_wf_byte_fifo: DEPTH must cover the lane counts");
   end

   logic [BW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic [CW-1:0] free;

   assign free  = CW'(DEPTH) - cnt;
   assign count = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         wptr <= wptr + AW'(push_n);
         rptr <= rptr + AW'(pop_n);
         cnt  <= cnt + CW'(push_n) - CW'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < WR_LANES; k++) begin
         if (!clr && (k < int'(push_n)))
            mem[wptr + AW'(k)] <= din[k*BW +: BW];
      end
   end

   // Read lanes beyond the stored byte count are forced to zero.
   for (genvar j = 0; j < RD_LANES; j++) begin : g_rd
      logic [AW-1:0] idx;
      assign idx = rptr + AW'(j);
      assign dout[j*BW +: BW] = (CW'(j) < cnt) ? mem[idx] : '0;
   end

   // R1: the occupancy never exceeds the depth
   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   // R8: a push is only ever requested into free space
   p_push_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> CW'(push_n) <= free);
   // R7: a pop never asks for more bytes than are held
   p_pop_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(pop_n) <= cnt);
   // R9: a clear leaves the FIFO empty on the next cycle
   p_clr_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo
   import spi_wf_pkg::*;
#(
   parameter int unsigned DEPTH  = DEF_DEPTH,
   parameter int unsigned LANES  = DEF_LANES,
   parameter int unsigned BYTE_W = DEF_BYTE_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          soft_rst,
   input  logic                          tx_swap,
   input  logic                          rx_swap,
   input  logic [$clog2(DEPTH+1)-1:0]    pkt_bytes,
   input  logic                          tx_wr,
   input  logic [LANES*BYTE_W-1:0]       tx_wdata,
   output logic                          tx_ovf,
   output logic [BYTE_W-1:0]             tx_byte,
   output logic                          tx_avail,
   input  logic                          tx_take,
   input  logic [BYTE_W-1:0]             rx_byte,
   input  logic                          rx_push,
   output logic                          rx_avail,
   input  logic                          rx_rd,
   output logic [LANES*BYTE_W-1:0]       rx_rdata
);
   localparam int unsigned WW = LANES * BYTE_W;
   localparam int unsigned CW = $clog2(DEPTH+1);
   localparam int unsigned NW = $clog2(LANES+1);

   if (LANES < 1 || BYTE_W < 1) begin : g_bad_cfg
      $error("spi_word_fifo: LANES and BYTE_W must be at least 1");
   end

   // ---------------- transmit side ----------------
   logic [WW-1:0] tx_lanes;
   logic [CW-1:0] tx_cnt, tx_acc, tx_rem, tx_free, tx_sum;
   logic [NW-1:0] tx_n, tx_push_n;
   logic          tx_go, tx_fit, tx_reject, tx_pop;

   spi_wf_lane_order #(.LANES(LANES), .BW(BYTE_W)) u_tx_order (
      .swap (tx_swap),
      .din  (tx_wdata),
      .dout (tx_lanes)
   );

   assign tx_rem    = pkt_bytes - tx_acc;
   assign tx_n      = (tx_rem >= CW'(LANES)) ? NW'(LANES) : NW'(tx_rem);
   assign tx_free   = CW'(DEPTH) - tx_cnt;
   assign tx_fit    = CW'(tx_n) <= tx_free;
   assign tx_go     = tx_wr && !soft_rst;
   assign tx_push_n = (tx_go && tx_fit) ? tx_n : '0;
   assign tx_reject = tx_go && (tx_n != '0) && !tx_fit;
   assign tx_sum    = tx_acc + CW'(tx_push_n);
   assign tx_pop    = tx_take && (tx_cnt != '0);
   assign tx_avail  = tx_cnt != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_acc <= '0;
         tx_ovf <= 1'b0;
      end else if (soft_rst) begin
         tx_acc <= '0;
         tx_ovf <= 1'b0;
      end else begin
         if (tx_push_n != '0)
            tx_acc <= (tx_sum == pkt_bytes) ? '0 : tx_sum;
         if (tx_reject)
            tx_ovf <= 1'b1;
      end
   end

   spi_wf_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(LANES), .RD_LANES(1), .BW(BYTE_W)) u_tx_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst),
      .push_n (tx_push_n),
      .din    (tx_lanes),
      .pop_n  (tx_pop),
      .dout   (tx_byte),
      .count  (tx_cnt)
   );

   // ---------------- receive side ----------------
   logic [WW-1:0] rx_lanes;
   logic [CW-1:0] rx_cnt;
   logic [NW-1:0] rx_pop_n;
   logic          rx_in;

   assign rx_in    = rx_push && (rx_cnt != CW'(DEPTH));
   assign rx_pop_n = !rx_rd ? '0 :
                     (rx_cnt >= CW'(LANES)) ? NW'(LANES) : NW'(rx_cnt);
   assign rx_avail = rx_cnt != '0;

   spi_wf_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(1), .RD_LANES(LANES), .BW(BYTE_W)) u_rx_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst),
      .push_n (rx_in),
      .din    (rx_byte),
      .pop_n  (rx_pop_n),
      .dout   (rx_lanes),
      .count  (rx_cnt)
   );

   spi_wf_lane_order #(.LANES(LANES), .BW(BYTE_W)) u_rx_order (
      .swap (rx_swap),
      .din  (rx_lanes),
      .dout (rx_rdata)
   );

   // R8: the overflow flag holds until a soft reset
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !soft_rst) |=> tx_ovf);
   // R8: the overflow flag only rises after a write strobe
   p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ovf) |-> $past(tx_wr));
   // R9: a soft reset empties both sides and clears the flag
   p_soft_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!tx_avail && !rx_avail && !tx_ovf));
   // R7: an empty receive FIFO reads as zero
   p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_avail |-> rx_rdata == '0);
endmodule

// File: tb/sim_spi_word_fifo.sv
module sim_spi_word_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n, soft_rst, tx_swap, rx_swap, tx_wr, tx_take, rx_push, rx_rd;
   logic [5:0]  pkt_bytes;
   logic [31:0] tx_wdata, rx_rdata;
   logic [7:0]  tx_byte, rx_byte;
   logic        tx_ovf, tx_avail, rx_avail;

   int checks = 0;
   int fails  = 0;

   logic [7:0] txq[$];
   logic [7:0] rxq[$];
   int  m_acc = 0;
   int  m_pkt = 0;
   bit  m_ovf = 1'b0;

   spi_word_fifo u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_swap(tx_swap), .rx_swap(rx_swap),
      .pkt_bytes(pkt_bytes), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_ovf(tx_ovf),
      .tx_byte(tx_byte), .tx_avail(tx_avail), .tx_take(tx_take), .rx_byte(rx_byte),
      .rx_push(rx_push), .rx_avail(rx_avail), .rx_rd(rx_rd), .rx_rdata(rx_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_pkt(input int n);
      m_pkt = n;
      pkt_bytes = 6'(n);
   endtask

   // Driver: predicts the accepted bytes, then strobes the word in.
   task automatic write_word(input logic [31:0] w, input bit swap);
      int rem, n;
      rem = (m_pkt - m_acc) & 63;
      n = (rem >= 4) ? 4 : rem;
      if (n > 0) begin
         if (n <= DEPTH - txq.size()) begin
            for (int k = 0; k < n; k++) begin
               int lane;
               lane = swap ? 3 - k : k;
               txq.push_back(w[lane*8 +: 8]);
            end
            m_acc += n;
            if (m_acc == m_pkt) m_acc = 0;
         end else begin
            m_ovf = 1'b1;
         end
      end
      tx_swap = swap; tx_wdata = w; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   // Monitor: takes every transmit byte and compares it with the queue.
   task automatic tx_monitor(input string tag);
      while (txq.size() > 0) begin
         logic [7:0] e;
         e = txq.pop_front();
         chk({tag, " tx_avail"}, {31'd0, tx_avail}, 32'd1);
         chk({tag, " tx_byte"}, {24'd0, tx_byte}, {24'd0, e});
         tx_take = 1'b1;
         @(negedge clk);
         tx_take = 1'b0;
      end
      chk({tag, " tx drained"}, {31'd0, tx_avail}, 32'd0);
   endtask

   task automatic feed_rx(input logic [7:0] b);
      if (rxq.size() < DEPTH) rxq.push_back(b);
      rx_byte = b; rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic read_rx(input bit swap, input string tag);
      logic [31:0] e;
      int n;
      e = '0;
      n = (rxq.size() >= 4) ? 4 : rxq.size();
      for (int k = 0; k < n; k++) begin
         int lane;
         lane = swap ? 3 - k : k;
         e[lane*8 +: 8] = rxq.pop_front();
      end
      rx_swap = swap; rx_rd = 1'b1;
      #1;
      chk({tag, " rx_rdata"}, rx_rdata, e);
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic do_soft_rst();
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      txq.delete(); rxq.delete();
      m_acc = 0; m_ovf = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; soft_rst = 1'b0; tx_swap = 1'b0; rx_swap = 1'b0; tx_wr = 1'b0;
      tx_take = 1'b0; rx_push = 1'b0; rx_rd = 1'b0; tx_wdata = '0; rx_byte = '0;
      set_pkt(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9 reset tx_avail", {31'd0, tx_avail}, 32'd0);
      chk("R9 reset rx_avail", {31'd0, rx_avail}, 32'd0);
      chk("R9 reset tx_ovf", {31'd0, tx_ovf}, 32'd0);
      chk("R9 reset rx_rdata", rx_rdata, 32'd0);

      // R1 fill with 32 bytes, R8 overflow on the ninth word, R2 order
      set_pkt(32);
      for (int i = 0; i < 8; i++) write_word(32'h03020100 + i * 32'h04040404, 1'b0);
      chk("R1 full without overflow", {31'd0, tx_ovf}, 32'd0);
      write_word(32'hDEADBEEF, 1'b0);
      chk("R8 overflow set", {31'd0, tx_ovf}, {31'd0, m_ovf});
      tx_monitor("R2");
      chk("R8 overflow sticky", {31'd0, tx_ovf}, 32'd1);
      do_soft_rst();
      chk("R9 overflow cleared", {31'd0, tx_ovf}, 32'd0);

      // R3 swapped order, R11 next packet
      set_pkt(8);
      write_word(32'hA1B2C3D4, 1'b1);
      write_word(32'h11223344, 1'b1);
      tx_monitor("R3");
      write_word(32'h55667788, 1'b0);
      write_word(32'h99AABBCC, 1'b0);
      tx_monitor("R11");

      // R4 trimmed final word, both orders
      set_pkt(7);
      write_word(32'h0D0C0B0A, 1'b0);
      write_word(32'h4F3E2D1C, 1'b0);
      tx_monitor("R4 straight");
      set_pkt(6);
      write_word(32'h76543210, 1'b1);
      write_word(32'hFEDCBA98, 1'b1);
      tx_monitor("R4 swapped");
      chk("R8 no overflow on trim", {31'd0, tx_ovf}, 32'd0);

      // R5 / R7 receive, straight order
      for (int i = 0; i < 6; i++) feed_rx(8'h60 + 8'(i));
      read_rx(1'b0, "R5");
      read_rx(1'b0, "R7 partial");
      read_rx(1'b0, "R7 empty");
      chk("R7 empty rx_avail", {31'd0, rx_avail}, 32'd0);
      // R6 receive, swapped order
      for (int i = 0; i < 5; i++) feed_rx(8'hC0 + 8'(i));
      read_rx(1'b1, "R6");
      read_rx(1'b1, "R6 partial");
      // R7: empty read does not disturb later bytes
      feed_rx(8'h5A);
      read_rx(1'b0, "R7 after empty");

      // R10 full receive FIFO drops the extra byte
      for (int i = 0; i < 33; i++) feed_rx(8'(i + 1));
      for (int i = 0; i < 8; i++) read_rx(1'b0, "R10");
      chk("R10 rx empty", {31'd0, rx_avail}, 32'd0);

      // R9 soft reset with contents, packet count restarts
      set_pkt(10);
      write_word(32'h01020304, 1'b0);
      write_word(32'h05060708, 1'b0);
      feed_rx(8'hAA); feed_rx(8'hBB); feed_rx(8'hCC);
      do_soft_rst();
      chk("R9 tx emptied", {31'd0, tx_avail}, 32'd0);
      chk("R9 rx emptied", {31'd0, rx_avail}, 32'd0);
      write_word(32'h0A0B0C0D, 1'b0);
      tx_monitor("R9 count restart");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule